// File: doc/BRIEF.md
# Abstract Register-Access Command Generator

This block sits inside a debug controller and turns a 32-bit abstract command word into a small program for a halted hart. When the debugger posts a register-access command, the block checks it and, if it is accepted, produces four debug ROM word writes in one cycle. Two of them go to the code window. One is a load or store between a general-purpose register and the data exchange address. The other is an `ebreak`. The third write patches the selected hart's entry slot with a `jal` that jumps into the code window. The fourth patches the hart's exception slot with a `jal` that leads back to the entry slot. The same strobe tells the surrounding controller to set its busy flag.

A command that cannot run does not launch. Instead the block reports an error code, which the controller latches into its sticky error field. While that field holds any code other than "none", new commands are dropped without any effect. The controller supplies the current busy flag, the error field, the selected hart index and the per-hart halted flags. All outputs are registered and valid one clock after the command strobe.

Top module: `abs_cmd_gen`

## Requirements
- R1: When `cmd_valid_i` is high and `err_i` is nonzero, neither `launch_o` nor `err_we_o` is asserted in the following cycle.
- R2: With `err_i` = 0 and `busy_i` high, a command yields `err_we_o` with `err_code_o` = 1 (busy) and no launch.
- R3: Command type is bits 31:24; any nonzero type yields error code 2 (not supported).
- R4: Register number is bits 15:0 and must lie in 0x1000..0x101F; the register index is regno minus 0x1000. Any other number yields error code 2.
- R5: If `halted_i[hart_sel_i]` is low, the command yields error code 4 (halt/resume).
- R6: Size is bits 22:20 and the write flag is bit 16. Size 2 uses funct3 010 and size 3 uses funct3 011; every other size yields error code 2. Write=1 gives `code0_o` = load (opcode 0000011, rd = index, rs1 = x0, imm = XCHG_ADDR). Write=0 gives a store (opcode 0100011, rs2 = index, rs1 = x0, imm = XCHG_ADDR).
- R7: On launch, `code1_o` = 32'h00100073 (`ebreak`) and `slot_idx_o` = `hart_sel_i`. Let slot = ENTRY_BASE + 4*hart. Then `entry_word_o` is `jal x0` with offset CODE_BASE − slot, and `exc_word_o` is `jal x0` with offset slot − EXC_BASE. Both use the J-type immediate layout and opcode 1101111.
- R8: Outputs change exactly one cycle after a strobe. Without a strobe, neither `launch_o` nor `err_we_o` is asserted. `launch_o` and `err_we_o` are never high together, and all outputs are 0 after reset.
- R9: Checks apply in this priority: busy, then type, then register range, then halted, then size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 32 | Abstract command word |
| hart_sel_i | input | HART_W | Selected hart index |
| halted_i | input | NHARTS | Per-hart halted flags |
| busy_i | input | 1 | Current busy flag |
| err_i | input | 3 | Current sticky error field |
| launch_o | output | 1 | Write all four ROM words and set busy |
| code0_o | output | 32 | Code window word 0 (load/store) |
| code1_o | output | 32 | Code window word 1 (ebreak) |
| slot_idx_o | output | HART_W | Entry/exception slot index |
| entry_word_o | output | 32 | Entry slot word |
| exc_word_o | output | 32 | Exception slot word |
| err_we_o | output | 1 | Error field update strobe |
| err_code_o | output | 3 | Error code to latch |

## Verification
Accepted commands cover both access sizes, both directions, several harts and both ends of the register range. These cases separate the funct3 and opcode choice, register field placement, and the per-hart `jal` offsets with their signs. Rejected commands each break one check at a time: busy, a nonzero type, a register number just outside the range on either side, a hart that is not halted, and an unsupported size. Each one shows which error code that check selects. Commands that break two checks at once confirm the priority order. A command sent with a pending error confirms that nothing is launched and nothing is reported.

// File: rtl/abs_cmd_pkg.sv
package abs_cmd_pkg;
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BUSY   = 3'd1,
    ERR_NOTSUP = 3'd2,
    ERR_EXC    = 3'd3,
    ERR_HALT   = 3'd4
  } err_e;

  localparam logic [6:0]  OP_LOAD  = 7'b0000011;
  localparam logic [6:0]  OP_STORE = 7'b0100011;
  localparam logic [6:0]  OP_JAL   = 7'b1101111;
  localparam logic [2:0]  F3_WORD  = 3'b010;
  localparam logic [2:0]  F3_DBL   = 3'b011;
  localparam logic [31:0] EBREAK   = 32'h00100073;
  localparam logic [15:0] GPR_LO   = 16'h1000;
  localparam logic [15:0] GPR_HI   = 16'h101F;

  // jal x0 with J-type immediate scramble
  function automatic logic [31:0] jal_x0(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, OP_JAL};
  endfunction
endpackage

// File: rtl/abs_cmd_decode.sv
module abs_cmd_decode
  import abs_cmd_pkg::*;
#(
  parameter int NHARTS = 4,
  parameter int HART_W = 2
) (
  input  logic [31:0]       cmd_i,
  input  logic [HART_W-1:0] hart_i,
  input  logic [NHARTS-1:0] halted_i,
  input  logic              busy_i,
  output err_e              verdict_o,
  output logic              ok_o,
  output logic [4:0]        gpr_o,
  output logic              wr_o,
  output logic              dbl_o
);
  logic [7:0]  cmd_type;
  logic [2:0]  cmd_size;
  logic [15:0] regno;
  logic        reg_ok;
  logic        size_ok;
  logic        hart_halted;

  assign cmd_type = cmd_i[31:24];
  assign cmd_size = cmd_i[22:20];
  assign regno    = cmd_i[15:0];
  assign wr_o     = cmd_i[16];
  assign dbl_o    = (cmd_size == 3'd3);
  assign gpr_o    = regno[4:0];
  assign reg_ok   = (regno >= GPR_LO) && (regno <= GPR_HI);
  assign size_ok  = (cmd_size == 3'd2) || (cmd_size == 3'd3);

  always_comb begin
    hart_halted = 1'b0;
    if (32'(hart_i) < NHARTS) hart_halted = halted_i[hart_i];
  end

  always_comb begin
    if (busy_i)                 verdict_o = ERR_BUSY;
    else if (cmd_type != 8'd0)  verdict_o = ERR_NOTSUP;
    else if (!reg_ok)           verdict_o = ERR_NOTSUP;
    else if (!hart_halted)      verdict_o = ERR_HALT;
    else if (!size_ok)          verdict_o = ERR_NOTSUP;
    else                        verdict_o = ERR_NONE;
  end

  assign ok_o = (verdict_o == ERR_NONE);
endmodule

// File: rtl/abs_cmd_encode.sv
module abs_cmd_encode
  import abs_cmd_pkg::*;
#(
  parameter int HART_W     = 2,
  parameter int ENTRY_BASE = 'h100,
  parameter int CODE_BASE  = 'h200,
  parameter int EXC_BASE   = 'h300,
  parameter int XCHG_ADDR  = 'h380
) (
  input  logic [HART_W-1:0] hart_i,
  input  logic [4:0]        gpr_i,
  input  logic              wr_i,
  input  logic              dbl_i,
  output logic [31:0]       code0_o,
  output logic [31:0]       code1_o,
  output logic [31:0]       entry_o,
  output logic [31:0]       exc_o
);
  localparam logic [11:0] XIMM = 12'(XCHG_ADDR);

  logic [2:0]  f3;
  logic [20:0] slot;
  logic [20:0] off_entry;
  logic [20:0] off_exc;

  assign f3        = dbl_i ? F3_DBL : F3_WORD;
  assign slot      = 21'(ENTRY_BASE) + 21'({hart_i, 2'b00});
  assign off_entry = 21'(CODE_BASE) - slot;
  assign off_exc   = slot - 21'(EXC_BASE);

  // register write -> load into gpr; register read -> store from gpr
  assign code0_o = wr_i ? {XIMM, 5'd0, f3, gpr_i, OP_LOAD}
                        : {XIMM[11:5], gpr_i, 5'd0, f3, XIMM[4:0], OP_STORE};
  assign code1_o = EBREAK;
  assign entry_o = jal_x0(off_entry);
  assign exc_o   = jal_x0(off_exc);
endmodule

// File: rtl/abs_cmd_gen.sv
module abs_cmd_gen
  import abs_cmd_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int HART_W     = (NHARTS > 1) ? $clog2(NHARTS) : 1,
  parameter int ENTRY_BASE = 'h100,
  parameter int CODE_BASE  = 'h200,
  parameter int EXC_BASE   = 'h300,
  parameter int XCHG_ADDR  = 'h380
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_word_i,
  input  logic [HART_W-1:0] hart_sel_i,
  input  logic [NHARTS-1:0] halted_i,
  input  logic              busy_i,
  input  logic [2:0]        err_i,
  output logic              launch_o,
  output logic [31:0]       code0_o,
  output logic [31:0]       code1_o,
  output logic [HART_W-1:0] slot_idx_o,
  output logic [31:0]       entry_word_o,
  output logic [31:0]       exc_word_o,
  output logic              err_we_o,
  output logic [2:0]        err_code_o
);
  err_e        verdict;
  logic        ok;
  logic [4:0]  gpr;
  logic        wr;
  logic        dbl;
  logic [31:0] w_code0, w_code1, w_entry, w_exc;
  logic        take;

  abs_cmd_decode #(.NHARTS(NHARTS), .HART_W(HART_W)) u_dec (
    .cmd_i(cmd_word_i), .hart_i(hart_sel_i), .halted_i(halted_i), .busy_i(busy_i),
    .verdict_o(verdict), .ok_o(ok), .gpr_o(gpr), .wr_o(wr), .dbl_o(dbl)
  );

  abs_cmd_encode #(
    .HART_W(HART_W), .ENTRY_BASE(ENTRY_BASE), .CODE_BASE(CODE_BASE),
    .EXC_BASE(EXC_BASE), .XCHG_ADDR(XCHG_ADDR)
  ) u_enc (
    .hart_i(hart_sel_i), .gpr_i(gpr), .wr_i(wr), .dbl_i(dbl),
    .code0_o(w_code0), .code1_o(w_code1), .entry_o(w_entry), .exc_o(w_exc)
  );

  // sticky error pending: drop command entirely
  assign take = cmd_valid_i && (err_i == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_o     <= 1'b0;
      err_we_o     <= 1'b0;
      err_code_o   <= 3'd0;
      code0_o      <= '0;
      code1_o      <= '0;
      slot_idx_o   <= '0;
      entry_word_o <= '0;
      exc_word_o   <= '0;
    end else begin
      launch_o   <= take && ok;
      err_we_o   <= take && !ok;
      if (take && !ok) err_code_o <= verdict;
      if (take && ok) begin
        code0_o      <= w_code0;
        code1_o      <= w_code1;
        slot_idx_o   <= hart_sel_i;
        entry_word_o <= w_entry;
        exc_word_o   <= w_exc;
      end
    end
  end
endmodule

module abs_cmd_gen_chk #(
  parameter int NHARTS = 4,
  parameter int HART_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [31:0]       cmd_word_i,
  input logic [HART_W-1:0] hart_sel_i,
  input logic [NHARTS-1:0] halted_i,
  input logic              busy_i,
  input logic [2:0]        err_i,
  input logic              launch_o,
  input logic [31:0]       code1_o,
  input logic              err_we_o,
  input logic [2:0]        err_code_o
);
  a_r1_pending_err_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && err_i != 3'd0) |=> (!launch_o && !err_we_o));

  a_r2_busy_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && err_i == 3'd0 && busy_i) |=> (err_we_o && err_code_o == 3'd1 && !launch_o));

  a_r3_bad_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && err_i == 3'd0 && !busy_i && cmd_word_i[31:24] != 8'd0)
      |=> (err_we_o && err_code_o == 3'd2));

  a_r5_needs_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !halted_i[hart_sel_i]) |=> !launch_o);

  a_r7_ebreak_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> code1_o == 32'h00100073);

  a_r8_no_strobe_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!launch_o && !err_we_o));

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && err_we_o));
endmodule

bind abs_cmd_gen abs_cmd_gen_chk #(.NHARTS(NHARTS), .HART_W(HART_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
  .hart_sel_i(hart_sel_i), .halted_i(halted_i), .busy_i(busy_i), .err_i(err_i),
  .launch_o(launch_o), .code1_o(code1_o), .err_we_o(err_we_o), .err_code_o(err_code_o)
);

// File: tb/abs_cmd_gen_test.sv
module abs_cmd_gen_test;
  localparam int NH = 4;
  localparam int HW = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic [HW-1:0] hart_sel_i = '0;
  logic [NH-1:0] halted_i = '0;
  logic        busy_i = 1'b0;
  logic [2:0]  err_i = '0;
  logic        launch_o, err_we_o;
  logic [31:0] code0_o, code1_o, entry_word_o, exc_word_o;
  logic [HW-1:0] slot_idx_o;
  logic [2:0]  err_code_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  abs_cmd_gen #(.NHARTS(NH)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int typ, input int size, input bit wr, input int regno);
    return {8'(typ), 1'b0, 3'(size), 3'b000, wr, 16'(regno)};
  endfunction

  function automatic logic [31:0] jal(input int off);
    logic [20:0] i;
    i = 21'(off);
    return {i[20], i[10:1], i[11], i[19:12], 5'd0, 7'h6f};
  endfunction

  function automatic logic [31:0] ld(input int rd, input bit dbl);
    return {12'h380, 5'd0, dbl ? 3'b011 : 3'b010, 5'(rd), 7'h03};
  endfunction

  function automatic logic [31:0] st(input int rs, input bit dbl);
    return {7'b0011100, 5'(rs), 5'd0, dbl ? 3'b011 : 3'b010, 5'd0, 7'h23};
  endfunction

  task automatic issue(input logic [31:0] w, input int hart, input logic [NH-1:0] hl,
                       input bit bsy, input int err);
    @(negedge clk_i);
    cmd_word_i = w; hart_sel_i = HW'(hart); halted_i = hl; busy_i = bsy; err_i = 3'(err);
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset launch", 32'(launch_o), 0);
    chk("R8 reset err_we", 32'(err_we_o), 0);
    chk("R8 reset code0", code0_o, 0);
  endtask

  task automatic t_quiet();
    @(negedge clk_i);
    cmd_word_i = mk(0, 2, 1, 'h1005); halted_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R8 no strobe launch", 32'(launch_o), 0);
    chk("R8 no strobe err_we", 32'(err_we_o), 0);
  endtask

  task automatic t_launch(input int hart, input int size, input bit wr, input int idx, input string tag);
    int slot;
    issue(mk(0, size, wr, 'h1000 + idx), hart, 4'hf, 0, 0);
    slot = 'h100 + 4 * hart;
    chk({tag, " launch"}, 32'(launch_o), 1);
    chk({tag, " err_we"}, 32'(err_we_o), 0);
    chk({tag, " code0"}, code0_o, wr ? ld(idx, size == 3) : st(idx, size == 3));
    chk("R7 ebreak", code1_o, 32'h00100073);
    chk("R7 slot idx", 32'(slot_idx_o), 32'(hart));
    chk("R7 entry jal", entry_word_o, jal('h200 - slot));
    chk("R7 exc jal", exc_word_o, jal(slot - 'h300));
  endtask

  task automatic t_err(input logic [31:0] w, input int hart, input logic [NH-1:0] hl,
                       input bit bsy, input int exp, input string tag);
    issue(w, hart, hl, bsy, 0);
    chk({tag, " launch"}, 32'(launch_o), 0);
    chk({tag, " err_we"}, 32'(err_we_o), 1);
    chk({tag, " code"}, 32'(err_code_o), 32'(exp));
  endtask

  task automatic t_ignored();
    issue(mk(0, 2, 1, 'h1001), 0, 4'hf, 0, 3);
    chk("R1 pending err launch", 32'(launch_o), 0);
    chk("R1 pending err err_we", 32'(err_we_o), 0);
    issue(mk(5, 7, 0, 'h0), 0, 4'h0, 1, 2);
    chk("R1 pending err bad cmd", 32'({launch_o, err_we_o}), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_quiet();
        t_launch(0, 2, 1, 5, "R6 word write");
        t_launch(2, 3, 0, 7, "R6 dbl read");
        t_launch(3, 2, 0, 0, "R4 low idx");
        t_launch(1, 3, 1, 31, "R4 high idx");
        t_err(mk(0, 2, 1, 'h1020), 0, 4'hf, 0, 2, "R4 above range");
        t_err(mk(0, 2, 1, 'h0fff), 0, 4'hf, 0, 2, "R4 below range");
        t_err(mk(1, 2, 1, 'h1000), 0, 4'hf, 0, 2, "R3 type 1");
        t_err(mk(2, 2, 0, 'h1000), 0, 4'hf, 0, 2, "R3 type 2");
        t_err(mk(0, 2, 1, 'h1003), 2, 4'b1011, 0, 4, "R5 not halted");
        t_err(mk(0, 4, 1, 'h1003), 0, 4'hf, 0, 2, "R6 size 4");
        t_err(mk(0, 1, 0, 'h1003), 0, 4'hf, 0, 2, "R6 size 1");
        t_err(mk(0, 2, 1, 'h1003), 0, 4'hf, 1, 1, "R2 busy");
        t_err(mk(9, 2, 1, 'h1003), 0, 4'hf, 1, 1, "R9 busy over type");
        t_err(mk(0, 2, 1, 'h2000), 1, 4'h0, 0, 2, "R9 range over halt");
        t_err(mk(0, 6, 1, 'h1002), 1, 4'h0, 0, 4, "R9 halt over size");
        t_ignored();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog act=timeout exp=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule